// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block sits beside the receive FIFO, transmit holding register and modem-status logic of a FIFO-equipped UART. It gathers five interrupt causes into one request line and an identification byte for the host to read. The five causes are line errors, receive data at or above a trigger level, receive character timeout, transmit holding empty and modem status change. Each cause is kept as a pending bit and masked by a four-bit enable input. The highest-priority enabled cause is encoded into the low nibble of the identification byte.

Line errors and modem changes stay pending until the matching status register is read. Receive data pending follows the FIFO fill level against a programmable trigger. The timeout cause watches for a stalled, non-empty FIFO, using a character time derived from the current frame format. Transmit-empty clears on a write to the holding register. It also clears on a read of the identification byte while that byte is showing transmit-empty. All pending bits are registered, and the identification byte and request are registered again. A cause therefore becomes visible two clock edges after the input that raised it.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset the identification byte reads 0x01 and the request output is low.
- R2: The request output is high exactly when an enabled cause is pending, and identification bit 0 is then 0. Both outputs reflect an input change two rising clock edges later.
- R3: Enable bit 0 gates both receive data and receive timeout, bit 1 gates transmit empty, bit 2 gates line errors and bit 3 gates modem change. A disabled cause neither raises the request nor appears in the code.
- R4: Codes in bits 3:0, from highest to lowest priority, are 0110 line error, 0100 receive data, 1100 receive timeout, 0010 transmit empty and 0000 modem change. 0001 means nothing is pending. Receive data is shown in preference to timeout when both are pending.
- R5: A pulse on any of the overrun, parity, framing or break inputs makes the line-error cause pending until a line-status read strobe. A modem delta pulse makes the modem cause pending until a modem-status read strobe.
- R6: With FIFO mode on, receive data is pending while the FIFO count is at least the trigger selected by the trigger select input: 00 means 1, 01 means 4, 10 means 8 and 11 means 14. With FIFO mode off, the trigger is 1.
- R7: With FIFO mode on and a non-empty FIFO, timeout becomes pending after 4 × (1 + 5 + word_len + parity + stop) bit-tick pulses with no push and no receive-buffer read. Stop counts 2 when the two-stop input is set and 1 otherwise. A receive-buffer read clears timeout, and timeout is never raised with FIFO mode off.
- R8: Transmit empty becomes pending on a rising edge of the holding-empty input. It clears on a holding-register write strobe, or on an identification read strobe while the identification byte shows 0010.
- R9: Setting enable bit 1 while the holding-empty input is already high makes transmit empty pending.
- R10: Identification bits 7:6 read 11 with FIFO mode on and 00 with it off, and bits 5:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_i | input | 4 | Interrupt enable bits |
| fifo_en_i | input | 1 | FIFO mode on |
| rx_trig_sel_i | input | 2 | Receive trigger select |
| word_len_i | input | 2 | Data bits minus 5 |
| parity_en_i | input | 1 | Frame has a parity bit |
| stop2_i | input | 1 | Frame has two stop bits |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_push_i | input | 1 | A character entered the receive FIFO |
| bit_tick_i | input | 1 | One pulse per bit time |
| overrun_i | input | 1 | Overrun event pulse |
| parity_err_i | input | 1 | Parity error event pulse |
| framing_err_i | input | 1 | Framing error event pulse |
| break_i | input | 1 | Break event pulse |
| modem_delta_i | input | 1 | Modem input change pulse |
| thr_empty_i | input | 1 | Transmit holding register empty level |
| rd_lsr_i | input | 1 | Line-status register read strobe |
| rd_msr_i | input | 1 | Modem-status register read strobe |
| rd_rbr_i | input | 1 | Receive buffer read strobe |
| rd_iir_i | input | 1 | Identification register read strobe |
| wr_thr_i | input | 1 | Holding register write strobe |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is the character timeout. It only occurs after dozens of bit ticks of complete FIFO silence, with data present but below the trigger. The bench holds the count under a 14-byte trigger and issues one push. It then runs a continuous tick for exactly the computed number of bit times and checks one edge before and one edge after the code appears. This is done for two frame formats so that the character length arithmetic is exercised. The identification-read clear of transmit empty is reached by raising holding-empty with only that cause enabled and strobing the read while the code is on display.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam logic [3:0] ID_NONE   = 4'b0001;
  localparam logic [3:0] ID_LINE   = 4'b0110;
  localparam logic [3:0] ID_RXDATA = 4'b0100;
  localparam logic [3:0] ID_RXTO   = 4'b1100;
  localparam logic [3:0] ID_THRE   = 4'b0010;
  localparam logic [3:0] ID_MODEM  = 4'b0000;

  localparam int MAX_CHAR_BITS = 12;

  typedef struct packed {
    logic line;
    logic rxdata;
    logic rxto;
    logic thre;
    logic modem;
  } irq_pend_t;

  function automatic int unsigned trigger_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // start + data + optional parity + stop (1.5 stop rounded to 2)
  function automatic int unsigned char_bits(input logic [1:0] wl,
                                            input logic par,
                                            input logic two_stop);
    return 32'd6 + 32'(wl) + 32'(par) + (two_stop ? 32'd2 : 32'd1);
  endfunction

endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_rxto.sv
module uart_irq_rxto
  import uart_irq_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int CHAR_TIMES = 4,
  localparam int TO_W      = $clog2(CHAR_TIMES * MAX_CHAR_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             activity_i,
  input  logic             bit_tick_i,
  input  logic [1:0]       word_len_i,
  input  logic             parity_en_i,
  input  logic             stop2_i,
  input  logic             clr_i,
  output logic             to_o
);
  logic [TO_W-1:0] limit;
  logic [TO_W-1:0] cnt_q;
  logic            empty;
  logic            hit;

  always_comb begin
    limit = TO_W'(CHAR_TIMES * char_bits(word_len_i, parity_en_i, stop2_i));
    empty = (rx_count_i == '0);
    hit   = en_i && !empty && !activity_i && bit_tick_i &&
            (cnt_q == limit - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      to_o  <= 1'b0;
    end else begin
      if (!en_i || clr_i) to_o <= 1'b0;
      else if (hit)       to_o <= 1'b1;

      if (!en_i || empty || activity_i) cnt_q <= '0;
      else if (bit_tick_i && !hit)      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk,
  input  logic rst,
  input  logic empty_i,
  input  logic enable_i,
  input  logic wr_thr_i,
  input  logic ack_i,
  output logic pend_o
);
  logic prev_empty_q;
  logic prev_en_q;
  logic set;

  always_comb begin
    set = (empty_i && !prev_empty_q) || (empty_i && enable_i && !prev_en_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_empty_q <= 1'b1;
      prev_en_q    <= 1'b0;
      pend_o       <= 1'b0;
    end else begin
      prev_empty_q <= empty_i;
      prev_en_q    <= enable_i;
      if (set)                    pend_o <= 1'b1;
      else if (wr_thr_i || ack_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int CHAR_TIMES  = 4,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ier_i,
  input  logic             fifo_en_i,
  input  logic [1:0]       rx_trig_sel_i,
  input  logic [1:0]       word_len_i,
  input  logic             parity_en_i,
  input  logic             stop2_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             rx_push_i,
  input  logic             bit_tick_i,
  input  logic             overrun_i,
  input  logic             parity_err_i,
  input  logic             framing_err_i,
  input  logic             break_i,
  input  logic             modem_delta_i,
  input  logic             thr_empty_i,
  input  logic             rd_lsr_i,
  input  logic             rd_msr_i,
  input  logic             rd_rbr_i,
  input  logic             rd_iir_i,
  input  logic             wr_thr_i,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  localparam int N_STICKY = 2;

  irq_pend_t         pend;
  irq_pend_t         live;
  logic [N_STICKY-1:0] st_set, st_clr, st_q;
  logic [CNT_W-1:0]  trig_eff;
  logic              rxdata_q;
  logic              rxto;
  logic              thre;
  logic              thre_ack;
  logic [3:0]        code;

  // sticky causes: index 0 line errors, index 1 modem change
  always_comb begin
    st_set[0] = overrun_i | parity_err_i | framing_err_i | break_i;
    st_clr[0] = rd_lsr_i;
    st_set[1] = modem_delta_i;
    st_clr[1] = rd_msr_i;
  end

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    uart_irq_flag flag_i (
      .clk    (clk),
      .rst    (rst),
      .set_i  (st_set[g]),
      .clr_i  (st_clr[g]),
      .flag_o (st_q[g])
    );
  end

  always_comb begin
    trig_eff = fifo_en_i ? CNT_W'(trigger_level(rx_trig_sel_i)) : CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) rxdata_q <= 1'b0;
    else     rxdata_q <= (rx_count_i >= trig_eff);
  end

  uart_irq_rxto #(.CNT_W(CNT_W), .CHAR_TIMES(CHAR_TIMES)) rxto_i (
    .clk         (clk),
    .rst         (rst),
    .en_i        (fifo_en_i),
    .rx_count_i  (rx_count_i),
    .activity_i  (rx_push_i | rd_rbr_i),
    .bit_tick_i  (bit_tick_i),
    .word_len_i  (word_len_i),
    .parity_en_i (parity_en_i),
    .stop2_i     (stop2_i),
    .clr_i       (rd_rbr_i),
    .to_o        (rxto)
  );

  always_comb begin
    thre_ack = rd_iir_i && (iir_o[3:0] == ID_THRE);
  end

  uart_irq_thre thre_i (
    .clk      (clk),
    .rst      (rst),
    .empty_i  (thr_empty_i),
    .enable_i (ier_i[1]),
    .wr_thr_i (wr_thr_i),
    .ack_i    (thre_ack),
    .pend_o   (thre)
  );

  always_comb begin
    pend.line   = st_q[0];
    pend.rxdata = rxdata_q;
    pend.rxto   = rxto;
    pend.thre   = thre;
    pend.modem  = st_q[1];

    live.line   = pend.line   & ier_i[2];
    live.rxdata = pend.rxdata & ier_i[0];
    live.rxto   = pend.rxto   & ier_i[0];
    live.thre   = pend.thre   & ier_i[1];
    live.modem  = pend.modem  & ier_i[3];

    if (live.line)        code = ID_LINE;
    else if (live.rxdata) code = ID_RXDATA;
    else if (live.rxto)   code = ID_RXTO;
    else if (live.thre)   code = ID_THRE;
    else if (live.modem)  code = ID_MODEM;
    else                  code = ID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_o <= {4'b0000, ID_NONE};
      irq_o <= 1'b0;
    end else begin
      iir_o <= {{2{fifo_en_i}}, 2'b00, code};
      irq_o <= |live;
    end
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] ier_i,
  input logic       overrun_i,
  input logic       parity_err_i,
  input logic       framing_err_i,
  input logic       break_i,
  input logic       rd_lsr_i,
  input logic [7:0] iir_o,
  input logic       irq_o
);
  logic any_err;
  always_comb any_err = overrun_i | parity_err_i | framing_err_i | break_i;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (iir_o == 8'h01 && !irq_o));

  a_r2_irq_vs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o == !iir_o[0]);

  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (ier_i == 4'h0) |=> !irq_o);

  a_r4_legal_code: assert property (@(posedge clk) disable iff (rst)
    iir_o[3:0] inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000});

  a_r5_lsr_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_lsr_i && !any_err) ##1 !any_err |=> iir_o[3:0] != 4'b0110);

  a_r10_mode_bits: assert property (@(posedge clk) disable iff (rst)
    (iir_o[7:6] == 2'b00 || iir_o[7:6] == 2'b11) && iir_o[5:4] == 2'b00);
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (.*);

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ier = 4'h0;
  logic       fifo_en = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic [1:0] word_len = 2'b11;
  logic       par_en = 1'b0;
  logic       stop2 = 1'b0;
  logic [4:0] rx_count = '0;
  logic       rx_push = 1'b0, bit_tick = 1'b0;
  logic       ovr = 1'b0, perr = 1'b0, ferr = 1'b0, brk = 1'b0;
  logic       mdelta = 1'b0, thr_empty = 1'b0;
  logic       rd_lsr = 1'b0, rd_msr = 1'b0, rd_rbr = 1'b0, rd_iir = 1'b0, wr_thr = 1'b0;
  logic [7:0] iir;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident dut_i (
    .clk(clk), .rst(rst), .ier_i(ier), .fifo_en_i(fifo_en),
    .rx_trig_sel_i(trig_sel), .word_len_i(word_len), .parity_en_i(par_en),
    .stop2_i(stop2), .rx_count_i(rx_count), .rx_push_i(rx_push),
    .bit_tick_i(bit_tick), .overrun_i(ovr), .parity_err_i(perr),
    .framing_err_i(ferr), .break_i(brk), .modem_delta_i(mdelta),
    .thr_empty_i(thr_empty), .rd_lsr_i(rd_lsr), .rd_msr_i(rd_msr),
    .rd_rbr_i(rd_rbr), .rd_iir_i(rd_iir), .wr_thr_i(wr_thr),
    .iir_o(iir), .irq_o(irq)
  );

  // {fifo_en, trig_sel, rx_count, ier, expected iir}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 2'b00, 5'd0,  4'hF, 8'hC1},
    {1'b1, 2'b00, 5'd1,  4'hF, 8'hC4},
    {1'b1, 2'b01, 5'd3,  4'hF, 8'hC1},
    {1'b1, 2'b01, 5'd4,  4'hF, 8'hC4},
    {1'b1, 2'b10, 5'd7,  4'hF, 8'hC1},
    {1'b1, 2'b10, 5'd8,  4'hF, 8'hC4},
    {1'b1, 2'b11, 5'd13, 4'hF, 8'hC1},
    {1'b1, 2'b11, 5'd14, 4'hF, 8'hC4},
    {1'b0, 2'b11, 5'd1,  4'hF, 8'h04},
    {1'b0, 2'b00, 5'd0,  4'hF, 8'h01},
    {1'b1, 2'b11, 5'd14, 4'h0, 8'hC1},
    {1'b1, 2'b11, 5'd14, 4'hE, 8'hC1}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_id(input string tag, input logic [7:0] exp);
    chk(tag, iir, exp);
    chk({tag, " irq"}, {7'b0, irq}, {7'b0, ~exp[0]});
  endtask

  task automatic timeout_run(input string tag, input int limit);
    rx_push = 1'b1;
    step(1);
    rx_push = 1'b0;
    bit_tick = 1'b1;
    step(limit);
    chk_id({tag, " before limit"}, 8'hC1);
    step(1);
    chk_id({tag, " at limit"}, 8'hCC);
    rd_rbr = 1'b1;
    step(1);
    rd_rbr = 1'b0;
    step(1);
    chk_id({tag, " rbr read clears"}, 8'hC1);
    bit_tick = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    chk_id("R1 reset", 8'h01);
    rst = 1'b0;
    step(1);

    // R6 R10 R3 R2: trigger levels, mode bits, masking
    for (int i = 0; i < NV; i++) begin
      fifo_en  = VEC[i][19];
      trig_sel = VEC[i][18:17];
      rx_count = VEC[i][16:12];
      ier      = VEC[i][11:8];
      step(2);
      chk_id($sformatf("R6/R10/R3/R2 vector %0d", i), VEC[i][7:0]);
    end

    // R4 R5: line errors above receive data, cleared by line-status read
    fifo_en = 1'b1; trig_sel = 2'b11; rx_count = 5'd14; ier = 4'hF;
    step(2);
    perr = 1'b1; step(1); perr = 1'b0; step(1);
    chk_id("R4 line over data", 8'hC6);
    rd_lsr = 1'b1; step(1); rd_lsr = 1'b0; step(1);
    chk_id("R5 lsr read clears", 8'hC4);
    brk = 1'b1; step(1); brk = 1'b0; step(1);
    chk_id("R5 break raises", 8'hC6);
    rd_lsr = 1'b1; step(1); rd_lsr = 1'b0; step(1);

    // R8: transmit empty set, cleared by identification read and by write
    rx_count = 5'd0; ier = 4'h2;
    step(2);
    thr_empty = 1'b1; step(2);
    chk_id("R8 empty rises", 8'hC2);
    rd_iir = 1'b1; step(1); rd_iir = 1'b0; step(1);
    chk_id("R8 id read clears", 8'hC1);
    thr_empty = 1'b0; step(1); thr_empty = 1'b1; step(2);
    chk_id("R8 empty rises again", 8'hC2);
    wr_thr = 1'b1; step(1); wr_thr = 1'b0; step(1);
    chk_id("R8 write clears", 8'hC1);

    // R5 R4: modem change lowest priority
    ier = 4'hA;
    mdelta = 1'b1; step(1); mdelta = 1'b0; step(1);
    chk_id("R5 modem raises", 8'hC0);
    thr_empty = 1'b0; step(1); thr_empty = 1'b1; step(2);
    chk_id("R4 thre over modem", 8'hC2);
    wr_thr = 1'b1; step(1); wr_thr = 1'b0; step(1);
    chk_id("R4 modem after thre", 8'hC0);
    rd_msr = 1'b1; step(1); rd_msr = 1'b0; step(1);
    chk_id("R5 msr read clears", 8'hC1);

    // R9: enabling while already empty
    ier = 4'h0; step(2);
    chk_id("R9 disabled", 8'hC1);
    ier = 4'h2; step(2);
    chk_id("R9 enable while empty", 8'hC2);
    wr_thr = 1'b1; step(1); wr_thr = 1'b0; step(1);

    // R7: timeout for 8N1 (40 ticks) and 7E2 (44 ticks)
    ier = 4'h1; rx_count = 5'd3;
    word_len = 2'b11; par_en = 1'b0; stop2 = 1'b0;
    step(2);
    timeout_run("R7 8N1", 40);
    word_len = 2'b10; par_en = 1'b1; stop2 = 1'b1;
    step(2);
    timeout_run("R7 7E2", 44);

    // R7 R6: no timeout with FIFO mode off, trigger 1
    fifo_en = 1'b0;
    rx_push = 1'b1; step(1); rx_push = 1'b0;
    bit_tick = 1'b1; step(80); bit_tick = 1'b0;
    chk_id("R7 no timeout fifo off", 8'h04);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule